// File: doc/BRIEF.md
# Set-Bounded Contiguous Slot Allocator

This block hands out runs of consecutive command slots from a 64-entry occupancy bitmap. The bitmap is divided, for each request, into equal sets of a given size, starting from slot 0. A requester asks for a number of slots, supplies the set size and how many sets may be used, and gets back either a set index with a starting offset inside that set, or an out-of-space verdict. A granted run always lies wholly inside one set. The granted slots are marked busy in the bitmap until a clear-all pulse empties it. Filling the slots with commands is done elsewhere.

The search runs over several cycles. It looks for the lowest run of free slots at or after a search start, which begins at slot 0. If that run would reach past the end of the set that holds the search start, the start moves to the next set and the search repeats. It stops when a run fits or when the search start has run past the permitted sets. One request is handled at a time. The result is shown for one cycle, and then the allocator returns to idle.

Top module: `slot_run_alloc`

## Requirements
- R1: After reset the bitmap is all zero, `busy` is 0 and `done_valid` is 0.
- R2: A request is taken only while `busy` is 0. A `req_valid` seen while busy produces no extra result and changes no bitmap bit.
- R3: On success the returned run is the lowest-addressed run of `req_count` free slots that lies entirely inside one set, among the first `req_sets` sets.
- R4: A granted run never crosses a set boundary: `done_slot + req_count <= req_per`.
- R5: When no such run exists, including the case `req_count > req_per`, the result is out-of-space (`done_ok` = 0) and the bitmap is left unchanged.
- R6: On success exactly `req_count` bits are set, at bitmap indices `done_set*req_per + done_slot` upward. Bit i of `slot_map` is slot i.
- R7: A cycle with `clear_all` high empties the whole bitmap by the next cycle. This takes priority over a grant in the same cycle.
- R8: A request with `req_count` of 0 or above 16, or with `req_per` of 0 or above 16, ends out-of-space without searching.
- R9: `busy` is 1 from the cycle after a request is accepted until the result cycle. `done_valid` is high for exactly one cycle, and `busy` is still 1 in that cycle.
- R10: When the lowest free run at or after the search start crosses the end of the current set, the search restarts at the first slot of the next set. For example, with sets of 4 and slots 0 to 2 taken, a request for 3 returns set 1, slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_all | input | 1 | Empty the whole bitmap |
| req_valid | input | 1 | Start an allocation (taken only when idle) |
| req_count | input | 5 | Number of consecutive slots wanted |
| req_per | input | 5 | Slots per set |
| req_sets | input | 7 | Number of sets that may be used |
| busy | output | 1 | Request in progress |
| done_valid | output | 1 | One-cycle result strobe |
| done_ok | output | 1 | 1 = run granted, 0 = out of space |
| done_set | output | 6 | Set index of the granted run |
| done_slot | output | 4 | Starting slot inside that set |
| slot_map | output | 64 | Current occupancy bitmap |

## Verification
The assertions assume that `clear_all` is not raised while a search is in flight. Under that assumption, any bitmap change other than a clear is a grant of exactly the requested size. They also assume that the request fields latched at acceptance describe the result that follows. The stimulus raises `clear_all` only while the allocator is idle. It keeps random counts and set sizes mostly in the legal range, with the illegal values applied only as directed cases. It drives one deliberate request during a busy search, to show that the request is dropped.

// File: rtl/sa_pkg.sv
// Shared types for the set-bounded slot allocator.
package sa_pkg;
    typedef enum logic [1:0] {
        SA_IDLE   = 2'd0,
        SA_SEARCH = 2'd1,
        SA_DONE   = 2'd2
    } sa_state_t;
endpackage

// File: rtl/sa_run_finder.sv
// Combinational search for the lowest run of COUNT zero bits starting at or
// above START. Assumes COUNT >= 1; runs may not extend past the map's top.
module sa_run_finder #(
    parameter int MAP_W   = 64,
    parameter int MAX_SET = 16,
    localparam int IDX_W  = $clog2(MAP_W),
    localparam int PTR_W  = IDX_W + 2,
    localparam int CNT_W  = $clog2(MAX_SET + 1)
) (
    input  logic [MAP_W-1:0] map_i,
    input  logic [PTR_W-1:0] start_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             found_o,
    output logic [IDX_W-1:0] pos_o
);
    logic [MAP_W-1:0] run_ones;
    logic [MAP_W-1:0] fits;

    // Build a mask of COUNT low-order ones.
    always_comb run_ones = ~({MAP_W{1'b1}} << count_i);

    // One free-window test per candidate start position.
    for (genvar p = 0; p < MAP_W; p++) begin : g_pos
        assign fits[p] = (((map_i >> p) & run_ones) == '0)
                      && ((p + int'(count_i)) <= MAP_W)
                      && (p >= int'(start_i));
    end

    // Priority pick of the lowest qualifying start.
    always_comb begin
        pos_o = '0;
        for (int i = MAP_W - 1; i >= 0; i--) begin
            if (fits[i]) pos_o = IDX_W'(i);
        end
        found_o = |fits;
    end
endmodule

// File: rtl/sa_run_mask.sv
// Produces the bitmap mask of COUNT ones starting at bit POS.
module sa_run_mask #(
    parameter int MAP_W   = 64,
    parameter int MAX_SET = 16,
    localparam int IDX_W  = $clog2(MAP_W),
    localparam int CNT_W  = $clog2(MAX_SET + 1)
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [IDX_W-1:0] pos_i,
    output logic [MAP_W-1:0] mask_o
);
    // Shift a COUNT-wide block of ones up to POS.
    always_comb mask_o = (~({MAP_W{1'b1}} << count_i)) << pos_i;
endmodule

// File: rtl/sa_slot_map.sv
// Holds the occupancy bitmap. Clear has priority over a set in the same cycle.
module sa_slot_map #(
    parameter int MAP_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             set_en_i,
    input  logic [MAP_W-1:0] set_mask_i,
    output logic [MAP_W-1:0] map_o
);
    // Bitmap register: reset, clear, or OR in a granted run.
    always_ff @(posedge clk) begin
        if (!rst_n)        map_o <= '0;
        else if (clear_i)  map_o <= '0;
        else if (set_en_i) map_o <= map_o | set_mask_i;
    end
endmodule

// File: rtl/sa_ctrl.sv
// Sequencer for the slot allocator. It latches a request in idle, steps the
// search start one set at a time, and presents a one-cycle result.
// Assumes the finder reports the lowest free run at or above start_o.
module sa_ctrl
    import sa_pkg::*;
#(
    parameter int MAP_W   = 64,
    parameter int MAX_SET = 16,
    localparam int IDX_W  = $clog2(MAP_W),
    localparam int PTR_W  = IDX_W + 2,
    localparam int CNT_W  = $clog2(MAX_SET + 1),
    localparam int SETS_W = $clog2(MAP_W + 1),
    localparam int SLOT_W = $clog2(MAX_SET),
    localparam int LIM_W  = SETS_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [CNT_W-1:0]  req_per,
    input  logic [SETS_W-1:0] req_sets,
    input  logic              found_i,
    input  logic [IDX_W-1:0]  pos_i,
    output logic [PTR_W-1:0]  start_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  per_o,
    output logic              set_en_o,
    output logic              busy,
    output logic              done_valid,
    output logic              done_ok,
    output logic [IDX_W-1:0]  done_set,
    output logic [SLOT_W-1:0] done_slot
);
    sa_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  per_q;
    logic [LIM_W-1:0]  limit_q;
    logic [PTR_W-1:0]  start_q;
    logic [PTR_W-1:0]  bound_q;
    logic [PTR_W-1:0]  set_q;
    logic              ok_q;
    logic [IDX_W-1:0]  set_res_q;
    logic [SLOT_W-1:0] slot_res_q;

    logic              req_bad;
    logic              out_of_room;
    logic              crosses;
    logic [PTR_W-1:0]  pos_ext;
    logic [PTR_W-1:0]  last_idx;

    // Reject counts or set sizes outside 1..MAX_SET.
    always_comb req_bad = (req_count == '0) || (req_count > CNT_W'(MAX_SET))
                       || (req_per == '0)   || (req_per > CNT_W'(MAX_SET));

    // Classify the current search step: no room, crossing, or fit.
    always_comb begin
        pos_ext     = PTR_W'(pos_i);
        last_idx    = pos_ext + PTR_W'(cnt_q) - PTR_W'(1);
        out_of_room = !found_i || (LIM_W'(pos_i) >= limit_q);
        crosses     = last_idx >= bound_q;
    end

    // State, latched request and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SA_IDLE;
            cnt_q      <= '0;
            per_q      <= '0;
            limit_q    <= '0;
            start_q    <= '0;
            bound_q    <= '0;
            set_q      <= '0;
            ok_q       <= 1'b0;
            set_res_q  <= '0;
            slot_res_q <= '0;
        end else begin
            case (state_q)
                SA_IDLE: begin
                    if (req_valid) begin
                        cnt_q      <= req_count;
                        per_q      <= req_per;
                        limit_q    <= LIM_W'(req_sets) * LIM_W'(req_per);
                        start_q    <= '0;
                        bound_q    <= PTR_W'(req_per);
                        set_q      <= '0;
                        ok_q       <= 1'b0;
                        set_res_q  <= '0;
                        slot_res_q <= '0;
                        state_q    <= req_bad ? SA_DONE : SA_SEARCH;
                    end
                end
                SA_SEARCH: begin
                    if (out_of_room) begin
                        ok_q    <= 1'b0;
                        state_q <= SA_DONE;
                    end else if (crosses) begin
                        start_q <= start_q + PTR_W'(per_q);
                        bound_q <= bound_q + PTR_W'(per_q);
                        set_q   <= set_q + PTR_W'(1);
                    end else begin
                        ok_q       <= 1'b1;
                        set_res_q  <= IDX_W'(set_q);
                        slot_res_q <= SLOT_W'(pos_ext - start_q);
                        state_q    <= SA_DONE;
                    end
                end
                default: state_q <= SA_IDLE;
            endcase
        end
    end

    // Drive the finder, the bitmap update and the outputs.
    always_comb begin
        start_o    = start_q;
        cnt_o      = cnt_q;
        per_o      = per_q;
        set_en_o   = (state_q == SA_SEARCH) && !out_of_room && !crosses;
        busy       = (state_q != SA_IDLE);
        done_valid = (state_q == SA_DONE);
        done_ok    = ok_q;
        done_set   = set_res_q;
        done_slot  = slot_res_q;
    end
endmodule

// File: rtl/slot_run_alloc.sv
// Top of the set-bounded contiguous slot allocator. It wires the sequencer,
// the run finder, the mask builder and the bitmap register together.
// Assumes one request at a time; requests while busy are dropped.
module slot_run_alloc #(
    parameter int MAP_W   = 64,
    parameter int MAX_SET = 16,
    localparam int IDX_W  = $clog2(MAP_W),
    localparam int PTR_W  = IDX_W + 2,
    localparam int CNT_W  = $clog2(MAX_SET + 1),
    localparam int SETS_W = $clog2(MAP_W + 1),
    localparam int SLOT_W = $clog2(MAX_SET)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic              req_valid,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [CNT_W-1:0]  req_per,
    input  logic [SETS_W-1:0] req_sets,
    output logic              busy,
    output logic              done_valid,
    output logic              done_ok,
    output logic [IDX_W-1:0]  done_set,
    output logic [SLOT_W-1:0] done_slot,
    output logic [MAP_W-1:0]  slot_map
);
    logic [PTR_W-1:0] search_start;
    logic [CNT_W-1:0] cur_cnt;
    logic [CNT_W-1:0] cur_per;
    logic             run_found;
    logic [IDX_W-1:0] run_pos;
    logic             grant_en;
    logic [MAP_W-1:0] grant_mask;

    sa_ctrl #(.MAP_W(MAP_W), .MAX_SET(MAX_SET)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_count(req_count), .req_per(req_per), .req_sets(req_sets),
        .found_i(run_found), .pos_i(run_pos), .start_o(search_start),
        .cnt_o(cur_cnt), .per_o(cur_per), .set_en_o(grant_en),
        .busy(busy), .done_valid(done_valid), .done_ok(done_ok),
        .done_set(done_set), .done_slot(done_slot)
    );

    sa_run_finder #(.MAP_W(MAP_W), .MAX_SET(MAX_SET)) u_find (
        .map_i(slot_map), .start_i(search_start), .count_i(cur_cnt),
        .found_o(run_found), .pos_o(run_pos)
    );

    sa_run_mask #(.MAP_W(MAP_W), .MAX_SET(MAX_SET)) u_mask (
        .count_i(cur_cnt), .pos_i(run_pos), .mask_o(grant_mask)
    );

    sa_slot_map #(.MAP_W(MAP_W)) u_map (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_all), .set_en_i(grant_en),
        .set_mask_i(grant_mask), .map_o(slot_map)
    );
endmodule

// File: rtl/sa_checker.sv
// Temporal checks for slot_run_alloc, attached by bind below.
// Assumes clear_all is raised only while the allocator is idle.
module sa_checker #(
    parameter int MAP_W   = 64,
    parameter int CNT_W   = 5,
    parameter int SLOT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_all,
    input logic              busy,
    input logic              done_valid,
    input logic              done_ok,
    input logic [SLOT_W-1:0] done_slot,
    input logic [MAP_W-1:0]  slot_map,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic [CNT_W-1:0]  cur_per
);
    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (slot_map == '0));

    // R9
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R9
    busy_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> busy);

    // R4
    no_straddle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_ok) |-> ((32'(done_slot) + 32'(cur_cnt)) <= 32'(cur_per)));

    // R2
    bits_only_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_all |=> ((slot_map & $past(slot_map)) == $past(slot_map)));

    // R6
    grant_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_ok && !$past(clear_all))
            |-> ($countones(slot_map ^ $past(slot_map)) == 32'(cur_cnt)));

    // R5
    fail_keeps_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_ok && !$past(clear_all)) |-> $stable(slot_map));
endmodule

bind slot_run_alloc sa_checker #(.MAP_W(MAP_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .busy(busy),
    .done_valid(done_valid), .done_ok(done_ok), .done_slot(done_slot),
    .slot_map(slot_map), .cur_cnt(cur_cnt), .cur_per(cur_per)
);

// File: tb/sim_slot_run_alloc.sv
`timescale 1ns/1ps
module sim_slot_run_alloc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_all = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_count = '0;
    logic [4:0]  req_per = '0;
    logic [6:0]  req_sets = '0;
    logic        busy, done_valid, done_ok;
    logic [5:0]  done_set;
    logic [3:0]  done_slot;
    logic [63:0] slot_map;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [63:0] ref_map = '0;
    bit          finished = 1'b0;

    slot_run_alloc u0 (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .req_valid(req_valid),
        .req_count(req_count), .req_per(req_per), .req_sets(req_sets),
        .busy(busy), .done_valid(done_valid), .done_ok(done_ok),
        .done_set(done_set), .done_slot(done_slot), .slot_map(slot_map)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Lowest in-set free run, or -1 when none or when the request is illegal.
    function automatic int model_find(logic [63:0] m, int cnt, int per, int sets);
        if (cnt < 1 || cnt > 16 || per < 1 || per > 16) return -1;
        for (int k = 0; k < sets; k++) begin
            for (int s = 0; s + cnt <= per; s++) begin
                int g = k * per + s;
                bit free = 1'b1;
                if (g + cnt > 64) return -1;
                for (int b = 0; b < cnt; b++) if (m[g + b]) free = 1'b0;
                if (free) return g;
            end
        end
        return -1;
    endfunction

    function automatic logic [63:0] run_bits(int g, int cnt);
        logic [63:0] r = '0;
        for (int b = 0; b < cnt; b++) r[g + b] = 1'b1;
        return r;
    endfunction

    task automatic do_req(input int cnt, input int per, input int sets, input string tag);
        int exp_g;
        int waited = 0;
        exp_g = model_find(ref_map, cnt, per, sets);
        @(negedge clk);
        req_valid = 1'b1;
        req_count = 5'(cnt);
        req_per   = 5'(per);
        req_sets  = 7'(sets);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R9 busy after accept", longint'(busy), 1);
        while (!done_valid && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        check(done_valid == 1'b1, {tag, " result seen"}, longint'(done_valid), 1);
        check(done_ok == (exp_g >= 0), {tag, " ok flag"}, longint'(done_ok), longint'(exp_g >= 0));
        if (exp_g >= 0) begin
            check(done_set == 6'(exp_g / per), {tag, " set index"}, longint'(done_set), longint'(exp_g / per));
            check(done_slot == 4'(exp_g % per), {tag, " start slot"}, longint'(done_slot), longint'(exp_g % per));
            ref_map = ref_map | run_bits(exp_g, cnt);
        end
        check(slot_map == ref_map, {tag, " R6 bitmap"}, longint'(slot_map), longint'(ref_map));
        @(negedge clk);
        check(!done_valid && !busy, "R9 single pulse", longint'({done_valid, busy}), 0);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear_all = 1'b1;
        @(negedge clk);
        clear_all = 1'b0;
        ref_map = '0;
        check(slot_map == 64'd0, "R7 clear", longint'(slot_map), 0);
    endtask

    initial begin
        int c, p, s;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(slot_map == 64'd0, "R1 map", longint'(slot_map), 0);
        check(!busy && !done_valid, "R1 flags", longint'({busy, done_valid}), 0);

        // R3 / R10 directed: sets of 4
        do_req(3, 4, 4, "R3 first");
        do_req(3, 4, 4, "R10 restart");
        do_req(1, 4, 4, "R3 lowest gap");
        do_req(5, 4, 4, "R5 too long");
        // R8 illegal requests
        do_req(0, 4, 4, "R8 zero count");
        do_req(17, 16, 4, "R8 count high");
        do_req(2, 0, 4, "R8 zero per");
        do_req(2, 17, 4, "R8 per high");
        // R5 fill until out-of-space
        for (int i = 0; i < 6; i++) do_req(2, 4, 4, "R5 fill");
        do_clear();
        do_req(4, 4, 4, "R7 after clear");

        // R2 request while busy is dropped
        do_clear();
        @(negedge clk);
        req_valid = 1'b1; req_count = 5'd2; req_per = 5'd8; req_sets = 7'd2;
        @(negedge clk);
        req_count = 5'd5;
        check(busy == 1'b1, "R2 busy", longint'(busy), 1);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done_valid) @(negedge clk);
        ref_map = run_bits(0, 2);
        @(negedge clk);
        repeat (4) begin
            check(!done_valid, "R2 no extra result", longint'(done_valid), 0);
            @(negedge clk);
        end
        check(slot_map == ref_map, "R2 map unchanged", longint'(slot_map), longint'(ref_map));

        // sets beyond the 64-bit map
        do_clear();
        for (int i = 0; i < 5; i++) do_req(16, 16, 8, "R5 beyond map");

        // R3 random mix
        do_clear();
        for (int i = 0; i < 150; i++) begin
            c = 1 + int'($urandom_range(0, 5));
            case ($urandom_range(0, 3))
                0: p = 4;
                1: p = 5;
                2: p = 8;
                default: p = 16;
            endcase
            s = 2 + int'($urandom_range(0, 10));
            do_req(c, p, s, "R3 random");
            if (i % 17 == 16) do_clear();
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule